// File: doc/BRIEF.md
# Buck Regulator Fault Supervisor

This block watches a buck regulator's output through a set of comparator flags. It decides when the regulator may switch, when it must be stopped, and when the output counts as good. Each fault flag is accepted only after a qualification delay of its own. An accepted fault is latched, and the latch places a fixed override on the gate commands that the switching sequencer obeys. An active-high power-good output is raised only after a start-up blanking window has elapsed, soft-start is complete and the output lies inside its window.

Over-voltage detection has two threshold modes: a fixed absolute level, or a level that scales with the reference. The reference-high input picks the comparator flag that counts, and the other flag has no effect. The under-voltage check is suppressed during the blanking window, so that a rising output is not taken for a fault. The over-voltage check stays armed from the start of that window. A latched fault stays in place until enable is dropped and raised again, or until the supply monitor loses and then regains its power-on-reset condition.

The controller has five named states:

- `ST_OFF`: the regulator is disabled or in lockout.
- `ST_BLANK`: the start-up blanking window is running.
- `ST_RUN`: normal regulation.
- `ST_OV`: an over-voltage fault is latched.
- `ST_UV`: an under-voltage fault is latched.

The transitions are:

- `ST_OFF` goes to `ST_BLANK` when the supply is good and enable is high.
- `ST_BLANK` goes to `ST_OV` on a qualified over-voltage, and to `ST_RUN` when the blanking count expires.
- `ST_RUN` goes to `ST_OV` on a qualified over-voltage, and otherwise to `ST_UV` on a qualified under-voltage.
- Every state returns to `ST_OFF` when enable is low or the supply is in lockout.

Top module: `buck_fault_supervisor`

## Requirements
- R1: While `por_ok_i` is low (supply lockout), the block enters `ST_OFF` at the next clock. There `hs_force_off_o`=1, `ls_force_off_o`=1, `ls_force_on_o`=0, `fault_code_o`=00 and `pgood_o`=0.
- R2: An over-voltage is accepted only after the selected over-voltage flag has been sampled high on OV_DLY consecutive clocks. A shorter pulse restarts the count and leaves no trace. The over-voltage check is armed in both `ST_BLANK` and `ST_RUN`.
- R3: An accepted over-voltage latches `ST_OV`. There `hs_force_off_o`=1, `ls_force_on_o`=1, `ls_force_off_o`=0 and `fault_code_o`=01.
- R4: An under-voltage is accepted only after `uv_i` has been sampled high on UV_DLY consecutive clocks in `ST_RUN`. A shorter pulse restarts the count.
- R5: An accepted under-voltage latches `ST_UV`. There `hs_force_off_o`=1, `ls_force_off_o`=1, `ls_force_on_o`=0 and `fault_code_o`=10.
- R6: In `ST_BLANK`, which lasts BLANK_CYC clocks after the block leaves `ST_OFF`, `uv_i` has no effect no matter how long it is held.
- R7: When `ref_high_i`=0 only `ov_abs_i` counts as over-voltage. When `ref_high_i`=1 only `ov_rel_i` counts. The unselected flag affects neither the fault logic nor power-good.
- R8: `pgood_o` is 0 in `ST_BLANK`. In `ST_RUN` it is 1 exactly when `ss_done_i`=1, `uv_i`=0 and the selected over-voltage flag is 0.
- R9: `pgood_o` drops in the same cycle that the output leaves its window, and it stays low from the moment a fault latches.
- R10: A latched fault code holds while enable and `por_ok_i` stay high. A low-then-high on `en_i` or on `por_ok_i` clears it and restarts through `ST_BLANK`.
- R11: With `en_i` low, the block is in `ST_OFF` with the outputs given in R1.
- R12: An active-low asynchronous reset places the block in `ST_OFF` and clears both qualification counts and the blanking count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Enable level |
| por_ok_i | input | 1 | Supply above power-on-reset level (low = lockout) |
| ov_abs_i | input | 1 | Output above the absolute over-voltage level |
| ov_rel_i | input | 1 | Output above the reference-scaled over-voltage level |
| ref_high_i | input | 1 | Reference above the mode-change point; selects `ov_rel_i` |
| uv_i | input | 1 | Output below the under-voltage fraction of the reference |
| ss_done_i | input | 1 | Soft-start complete |
| hs_force_off_o | output | 1 | Command: hold high-side gate off |
| ls_force_on_o | output | 1 | Command: hold low-side gate on |
| ls_force_off_o | output | 1 | Command: hold low-side gate off |
| pgood_o | output | 1 | Power good, active high |
| fault_code_o | output | 2 | Latched fault: 00 none, 01 over-voltage, 10 under-voltage |

## Verification
The assertions assume that all inputs are synchronous to `clk` and stable around its rising edge. They also assume that comparator flags which are already filtered come in as plain levels with no meaning between samples. The bench changes every input on the falling edge only and holds each pattern for a whole number of cycles. It places pulse lengths at least one clock clear of each qualification limit, so that no result depends on edge order.

// File: rtl/psup_pkg.sv
package psup_pkg;

    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_BLANK = 3'd1,
        ST_RUN   = 3'd2,
        ST_OV    = 3'd3,
        ST_UV    = 3'd4
    } sup_state_t;

    typedef enum logic [1:0] {
        FC_NONE = 2'b00,
        FC_OV   = 2'b01,
        FC_UV   = 2'b10
    } fault_code_t;

endpackage

// File: rtl/psup_qualify.sv
// Persistence filter: qual is high once flag has been sampled high on
// DLY consecutive clocks while armed; any low sample restarts the count.
module psup_qualify #(
    parameter int DLY = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic flag,
    output logic qual
);
    localparam int W = $clog2(DLY + 1);
    localparam logic [W-1:0] LIM = W'(DLY);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!(arm && flag)) begin
            cnt <= '0;
        end else if (cnt != LIM) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign qual = (cnt == LIM);

    // R2 R4
    qual_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(qual) |-> $past(arm && flag));

endmodule

// File: rtl/psup_blank.sv
// Start-up blanking timer: done after CYC clocks of run.
module psup_blank #(
    parameter int CYC = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int W = $clog2(CYC + 1);
    localparam logic [W-1:0] LAST = W'(CYC - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = run && (cnt == LAST);

    // R6
    blank_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(run));

endmodule

// File: rtl/buck_fault_supervisor.sv
module buck_fault_supervisor
    import psup_pkg::*;
#(
    parameter int OV_DLY    = 500,
    parameter int UV_DLY    = 300,
    parameter int BLANK_CYC = 250000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       por_ok_i,
    input  logic       ov_abs_i,
    input  logic       ov_rel_i,
    input  logic       ref_high_i,
    input  logic       uv_i,
    input  logic       ss_done_i,
    output logic       hs_force_off_o,
    output logic       ls_force_on_o,
    output logic       ls_force_off_o,
    output logic       pgood_o,
    output logic [1:0] fault_code_o
);
    sup_state_t st, nxt;
    logic       ov_sel, ov_q, uv_q, blank_done, go;
    fault_code_t code;

    // R7: threshold mode picks one comparator before qualification
    assign ov_sel = ref_high_i ? ov_rel_i : ov_abs_i;
    assign go     = en_i && por_ok_i;

    psup_qualify #(.DLY(OV_DLY)) u_ov_qual (
        .clk  (clk),
        .rst_n(rst_n),
        .arm  ((st == ST_BLANK) || (st == ST_RUN)),
        .flag (ov_sel),
        .qual (ov_q)
    );

    psup_qualify #(.DLY(UV_DLY)) u_uv_qual (
        .clk  (clk),
        .rst_n(rst_n),
        .arm  (st == ST_RUN),
        .flag (uv_i),
        .qual (uv_q)
    );

    psup_blank #(.CYC(BLANK_CYC)) u_blank (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (st == ST_BLANK),
        .done (blank_done)
    );

    // R12: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_OFF;
        end else begin
            st <= nxt;
        end
    end

    always_comb begin
        nxt = st;
        unique case (st)
            ST_OFF: begin
                if (go) nxt = ST_BLANK;
            end
            ST_BLANK: begin
                if (!go)             nxt = ST_OFF;
                else if (ov_q)       nxt = ST_OV;
                else if (blank_done) nxt = ST_RUN;
            end
            ST_RUN: begin
                if (!go)       nxt = ST_OFF;
                else if (ov_q) nxt = ST_OV;
                else if (uv_q) nxt = ST_UV;
            end
            ST_OV, ST_UV: begin
                if (!go) nxt = ST_OFF;
            end
            default: nxt = ST_OFF;
        endcase
    end

    // Output decode
    always_comb begin
        hs_force_off_o = 1'b1;
        ls_force_on_o  = 1'b0;
        ls_force_off_o = 1'b1;
        pgood_o        = 1'b0;
        code           = FC_NONE;
        unique case (st)
            ST_OFF: begin
            end
            ST_BLANK: begin
                hs_force_off_o = 1'b0;
                ls_force_off_o = 1'b0;
            end
            ST_RUN: begin
                hs_force_off_o = 1'b0;
                ls_force_off_o = 1'b0;
                pgood_o        = ss_done_i && !uv_i && !ov_sel;
            end
            ST_OV: begin
                ls_force_on_o  = 1'b1;
                ls_force_off_o = 1'b0;
                code           = FC_OV;
            end
            ST_UV: begin
                code = FC_UV;
            end
            default: begin
            end
        endcase
    end

    assign fault_code_o = code;

    // R1
    lockout_gates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !por_ok_i |=> (hs_force_off_o && ls_force_off_o && !ls_force_on_o
                       && fault_code_o == FC_NONE && !pgood_o));

    // R10
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_code_o != FC_NONE && en_i && por_ok_i) |=> $stable(fault_code_o));

    // R9
    pgood_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ov_q && st == ST_RUN) |=> !pgood_o);

endmodule

// File: tb/buck_fault_supervisor_bench.sv
module buck_fault_supervisor_bench;
    localparam int OV_DLY = 8;
    localparam int UV_DLY = 5;
    localparam int BLANK  = 30;
    localparam int NV     = 19;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 0, por = 1, ova = 0, ovr = 0, refhi = 0, uv = 0, ss = 0;
    logic hs_off, ls_on, ls_off, pg;
    logic [1:0] code;
    int n_chk = 0;
    int n_bad = 0;
    logic finished = 1'b0;

    always #2 clk = ~clk;

    buck_fault_supervisor #(
        .OV_DLY(OV_DLY), .UV_DLY(UV_DLY), .BLANK_CYC(BLANK)
    ) u_buck_fault_supervisor (
        .clk(clk), .rst_n(rst_n), .en_i(en), .por_ok_i(por),
        .ov_abs_i(ova), .ov_rel_i(ovr), .ref_high_i(refhi), .uv_i(uv),
        .ss_done_i(ss), .hs_force_off_o(hs_off), .ls_force_on_o(ls_on),
        .ls_force_off_o(ls_off), .pgood_o(pg), .fault_code_o(code)
    );

    // inputs {en,por,ova,ovr,refhi,uv,ss}, wait, expected {pg,code,hs,lson,lsoff}, req
    localparam logic [24:0] VEC [NV] = '{
        {7'b0100000, 8'd3,  6'b0_00_101, 4'd11}, // R11 disabled
        {7'b1100010, 8'd20, 6'b0_00_000, 4'd6},  // R6 uv ignored in blanking
        {7'b1100001, 8'd15, 6'b1_00_000, 4'd8},  // R8 pgood after blanking
        {7'b1100011, 8'd4,  6'b0_00_000, 4'd4},  // R4 short uv, R9 pgood low
        {7'b1100001, 8'd2,  6'b1_00_000, 4'd4},  // R4 count restarted
        {7'b1100011, 8'd7,  6'b0_10_101, 4'd5},  // R5 uv trip
        {7'b1100001, 8'd5,  6'b0_10_101, 4'd10}, // R10 latch holds
        {7'b0100001, 8'd2,  6'b0_00_101, 4'd11}, // R11 enable low
        {7'b1100001, 8'd35, 6'b1_00_000, 4'd10}, // R10 restart via enable
        {7'b1101001, 8'd12, 6'b1_00_000, 4'd7},  // R7 rel flag ignored
        {7'b1110001, 8'd7,  6'b0_00_000, 4'd2},  // R2 short ov
        {7'b1100001, 8'd2,  6'b1_00_000, 4'd2},  // R2 no trace
        {7'b1110001, 8'd10, 6'b0_01_110, 4'd3},  // R3 ov trip
        {7'b1000001, 8'd2,  6'b0_00_101, 4'd1},  // R1 lockout
        {7'b1100001, 8'd35, 6'b1_00_000, 4'd10}, // R10 restart via supply
        {7'b1110101, 8'd12, 6'b1_00_000, 4'd7},  // R7 abs flag ignored
        {7'b1101101, 8'd10, 6'b0_01_110, 4'd3},  // R3 rel ov trip
        {7'b0100101, 8'd2,  6'b0_00_101, 4'd11}, // R11
        {7'b1101100, 8'd12, 6'b0_01_110, 4'd2}   // R2 ov armed in blanking
    };

    task automatic check(input logic [5:0] exp, input int req, input int step);
        logic [5:0] got;
        got = {pg, code, hs_off, ls_on, ls_off};
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL R%0d step %0d: got %b expected %b", req, step, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(6'b0_00_101, 12, -1); // R12 reset state
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            {en, por, ova, ovr, refhi, uv, ss} = VEC[i][24:18];
            repeat (int'(VEC[i][17:10])) @(negedge clk);
            check(VEC[i][9:4], int'(VEC[i][3:0]), i);
        end
        // R12: reset while over-voltage is latched
        rst_n = 1'b0;
        @(negedge clk);
        check(6'b0_00_101, 12, 100);
        // R12 / R2: restart with ov flag held re-qualifies from zero
        rst_n = 1'b1;
        repeat (OV_DLY - 2) @(negedge clk);
        check(6'b0_00_000, 2, 101);
        repeat (4) @(negedge clk);
        check(6'b0_01_110, 3, 102);
        // R1: lockout overrides latched fault
        por = 1'b0;
        @(negedge clk);
        check(6'b0_00_101, 1, 103);
        finish_run();
    end
endmodule